// File: doc/BRIEF.md
# DMA Channel Error Status Aggregator

This block keeps a sticky error flag for each of the 16 channels of a multi-channel DMA engine and combines the flags into a single group error interrupt request. The engine raises a one-cycle pulse on a channel's error line, and that channel's flag then stays set until software clears it. The normal completion signalling of the engine never passes through this block.

Software reaches the block through a small word-addressed register port. It can clear flags in two ways. It can write a mask to the status word, where each one clears a channel. It can also write a channel number to a separate clear register, where a spare bit clears every channel at once. A per-channel enable register gates each flag before the flags are OR-ed into the interrupt request. The status word always reads back the raw flags, whatever the enables hold, so software can poll for errors with the interrupt masked.

Top module: `dma_err_agg`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0 and `err_irq` is 0.
- R2: A one on `err_pulse[i]` in a clock cycle sets status bit i at that clock edge. The bit stays set until software clears it. A status bit never becomes set without a pulse.
- R3: A write to address 0 (status) clears every status bit whose `reg_wdata` bit is 1. Status bits whose `reg_wdata` bit is 0 keep their value.
- R4: A write to address 2 (channel clear) with `reg_wdata[6]`=0 clears only the status bit of the channel numbered by `reg_wdata[3:0]`.
- R5: A write to address 2 with `reg_wdata[6]`=1 clears all 16 status bits, whatever `reg_wdata[3:0]` holds.
- R6: A read of address 0 returns the raw status bits (bit i = channel i), whatever the enable word holds. A read of address 2 returns 0.
- R7: When an error pulse and a software clear (from any path) hit the same channel in the same cycle, the bit ends up set.
- R8: `err_irq` is a registered OR over (status AND enable). It rises one clock after a gated status bit becomes set, and falls one clock after the last gated bit clears.
- R9: Address 1 is a 16-bit read/write enable word (bit i enables channel i). Writing it changes only the interrupt gating, never the status bits.
- R10: A write to address 3 changes neither the status nor the enable word, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 16 | Per-channel error pulses from the DMA engine |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 status, 1 enable, 2 channel clear) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| err_irq | output | 1 | Registered group error interrupt request |

## Verification
An error pulse or a register write takes effect on the next rising edge. The status word is combinational from that state, so it can be read back in the same cycle as the falling edge that follows the write. The interrupt has one more register in its path, so it is due one full cycle later. The bench checks it both at the first falling edge, where it must still hold the old value, and at the second, where it must hold the new one. All inputs change on falling edges. The scoreboard monitor samples a quarter period later, so every comparison sees settled values.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  // Register word addresses
  localparam int unsigned RA_STATUS = 0;
  localparam int unsigned RA_ENABLE = 1;
  localparam int unsigned RA_CHCLR  = 2;
  // Channel-clear register: bit that clears every channel at once
  localparam int unsigned CHCLR_ALL_BIT = 6;
  // Register address width
  localparam int unsigned REG_AW = 2;
endpackage

// File: rtl/err_reg_decode.sv
module err_reg_decode
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = REG_AW
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [NUM_CH-1:0] clr_vec,
  output logic              en_we
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  // Mask selected by a channel-clear write
  function automatic logic [NUM_CH-1:0] chclr_mask(input logic [NUM_CH-1:0] d);
    logic [NUM_CH-1:0] m;
    m = '0;
    if (d[CHCLR_ALL_BIT]) begin
      m = '1;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (d[CH_W-1:0] == CH_W'(i)) m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  logic wr_status;
  logic wr_chclr;

  assign wr_status = reg_we && (reg_addr == ADDR_W'(RA_STATUS));
  assign wr_chclr  = reg_we && (reg_addr == ADDR_W'(RA_CHCLR));
  assign en_we     = reg_we && (reg_addr == ADDR_W'(RA_ENABLE));

  always_comb begin
    clr_vec = '0;
    if (wr_status) clr_vec = reg_wdata;
    else if (wr_chclr) clr_vec = chclr_mask(reg_wdata);
  end
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] st_map
);
  // One sticky flag per channel; a set beats a clear in the same cycle
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          st_map[g] <= 1'b0;
      else if (set_vec[g]) st_map[g] <= 1'b1;
      else if (clr_vec[g]) st_map[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/err_irq_gate.sv
module err_irq_gate #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] st_map,
  input  logic [NUM_CH-1:0] en_map,
  output logic              irq_any,
  output logic              irq_q
);
  function automatic logic gated_any(input logic [NUM_CH-1:0] s,
                                     input logic [NUM_CH-1:0] e);
    return |(s & e);
  endfunction

  assign irq_any = gated_any(st_map, en_map);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_any;
  end
endmodule

// File: rtl/dma_err_agg.sv
module dma_err_agg
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] err_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic [NUM_CH-1:0] reg_rdata,
  output logic              err_irq
);
  logic [NUM_CH-1:0] st_map;
  logic [NUM_CH-1:0] en_map;
  logic [NUM_CH-1:0] clr_vec;
  logic              en_we;
  logic              irq_any;

  err_reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .clr_vec  (clr_vec),
    .en_we    (en_we)
  );

  err_status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(err_pulse),
    .clr_vec(clr_vec),
    .st_map (st_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_map <= '0;
    else if (en_we) en_map <= reg_wdata;
  end

  err_irq_gate #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_map (st_map),
    .en_map (en_map),
    .irq_any(irq_any),
    .irq_q  (err_irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(RA_STATUS): reg_rdata = st_map;
      ADDR_W'(RA_ENABLE): reg_rdata = en_map;
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_agg_chk.sv
module err_agg_chk
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = REG_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] err_pulse,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NUM_CH-1:0] reg_wdata,
  input logic [NUM_CH-1:0] reg_rdata,
  input logic              err_irq,
  input logic [NUM_CH-1:0] st_map,
  input logic [NUM_CH-1:0] en_map
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((st_map & $past(err_pulse)) == $past(err_pulse))); // R7

  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_map & ~$past(st_map) & ~$past(err_pulse)) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_STATUS) && err_pulse == '0)
      |=> ((st_map & $past(reg_wdata)) == '0)); // R3

  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_STATUS))
      |=> ((st_map & ~$past(reg_wdata)) ==
           (($past(st_map) | $past(err_pulse)) & ~$past(reg_wdata)))); // R3

  AST_CHCLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_CHCLR) && !reg_wdata[CHCLR_ALL_BIT] && err_pulse == '0)
      |=> (st_map[$past(reg_wdata[CH_W-1:0])] == 1'b0)); // R4

  AST_CHCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_CHCLR) && reg_wdata[CHCLR_ALL_BIT] && err_pulse == '0)
      |=> (st_map == '0)); // R5

  AST_READ_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(RA_STATUS)) |-> (reg_rdata == st_map)); // R6

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (err_irq == |($past(st_map) & $past(en_map)))); // R8

  AST_EN_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_ENABLE) && err_pulse == '0) |=> $stable(st_map)); // R9
endmodule

bind dma_err_agg err_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dma_err_agg.sv
module tb_dma_err_agg;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_ST = 2'd0, A_EN = 2'd1, A_CC = 2'd2, A_NO = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] err_pulse = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        err_irq;

  dma_err_agg dut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] m_st = '0;
  logic [15:0] m_en = '0;

  // Monitor: compare queued expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = it.is_irq ? {15'd0, err_irq} : reg_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, with the model updated from the requirements
  task automatic drive(input bit we, input logic [1:0] a, input logic [15:0] d,
                       input logic [15:0] p);
    logic [15:0] clr;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; err_pulse = p;
    clr = '0;
    if (we && a == A_ST) clr = d;
    if (we && a == A_CC) clr = d[6] ? 16'hFFFF : (16'h0001 << d[3:0]);
    if (we && a == A_EN) m_en = d;
    m_st = (m_st & ~clr) | p;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; err_pulse = '0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  function automatic logic m_irq();
    return |(m_st & m_en);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq");
    chk_rd(A_ST, 16'h0000, "R1 status");
    chk_rd(A_EN, 16'h0000, "R1 enable");

    drive(1'b0, A_ST, 16'h0, 16'h8008);
    chk_irq(1'b0, "R9 masked irq");
    chk_rd(A_ST, m_st, "R2 set by pulse / R6 raw with enable off");

    drive(1'b1, A_EN, 16'h8008, 16'h0);
    chk_rd(A_EN, 16'h8008, "R9 enable readback");
    chk_rd(A_ST, m_st, "R9 status untouched");
    @(negedge clk);
    chk_irq(m_irq(), "R8 irq after enable");

    drive(1'b1, A_ST, 16'h0008, 16'h0);
    chk_rd(A_ST, m_st, "R3 one clears");
    drive(1'b1, A_ST, 16'h0000, 16'h0);
    chk_rd(A_ST, m_st, "R3 zero keeps");

    drive(1'b1, A_CC, 16'h000F, 16'h0);
    chk_irq(1'b1, "R8 deassert lag");
    @(negedge clk);
    chk_irq(1'b0, "R8 deasserted");
    chk_rd(A_ST, m_st, "R4 clear channel 15");

    drive(1'b0, A_ST, 16'h0, 16'h0008);
    chk_irq(1'b0, "R8 assert lag");
    @(negedge clk);
    chk_irq(1'b1, "R8 asserted");

    drive(1'b0, A_ST, 16'h0, 16'hFFFF);
    drive(1'b1, A_CC, 16'h0005, 16'h0);
    chk_rd(A_ST, 16'hFFDF, "R4 clear channel 5 only");
    drive(1'b1, A_CC, 16'h0045, 16'h0);
    chk_rd(A_ST, 16'h0000, "R5 clear all");
    chk_rd(A_CC, 16'h0000, "R6 clear register reads zero");

    drive(1'b1, A_ST, 16'h0001, 16'h0001);
    chk_rd(A_ST, 16'h0001, "R7 set beats status clear");
    drive(1'b1, A_CC, 16'h0003, 16'h0008);
    chk_rd(A_ST, 16'h0009, "R7 set beats channel clear");
    drive(1'b1, A_CC, 16'h0040, 16'h0010);
    chk_rd(A_ST, 16'h0010, "R7 set beats clear all");

    drive(1'b1, A_NO, 16'hFFFF, 16'h0);
    chk_rd(A_ST, 16'h0010, "R10 status unchanged");
    chk_rd(A_EN, 16'h8008, "R10 enable unchanged");
    chk_rd(A_NO, 16'h0000, "R10 reads zero");

    drive(1'b1, A_EN, 16'h0000, 16'h0);
    drive(1'b0, A_ST, 16'h0, 16'h0008);
    @(negedge clk);
    chk_irq(1'b0, "R9 all masked");
    chk_rd(A_ST, m_st, "R6 raw status while masked");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule